// File: doc/BRIEF.md
# Cartridge Boot Hold Controller

This block sits on a cartridge port that carries a 13-bit address and an 8-bit data bus. It decides, once per clock, whether the cartridge drives the data bus and which byte it places there. The port has no read/write strobe, so every access with the top address bit set is treated as a cartridge read. Accesses with that bit clear belong to the console and are never driven.

From reset until the cartridge's own logic reports that it is ready, the block answers every cartridge access with an all-zero byte. The processor then keeps fetching a break opcode and vectoring through zero, wrapping its stack pointer. It never meets an opcode that would halt it, so initialisation may take as long as it needs. When the ready line rises, it passes through a two-flop synchroniser. The block then changes to normal service at the first address change that follows, never in the middle of an access. In normal service it returns a configured reset vector at the two top offsets, and bytes from a small computed ROM everywhere else.

Top module: `cart_boot_hold`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `bus_drive` is 0 and `bus_data` is 8'h00.
- R2: Before release, every access with address bit 12 set is answered on the next clock with `bus_drive`=1 and `bus_data`=8'h00. This holds at every offset, including 12'hFFE and 12'hFFF.
- R3: An access with address bit 12 clear gives `bus_drive`=0 and `bus_data`=8'h00 on the next clock, whether the block is holding or serving.
- R4: `boot_ready` passes through a two-stage synchroniser. An address change at the second clock edge after `boot_ready` rises still gets the held zero.
- R5: Release happens only at a clock edge where the address differs from the previous cycle's address and the synchronised ready is 1. While the address stays constant, the zero byte persists, however long ready has been high.
- R6: After release, offset 12'hFFE (bit 12 set) returns RESET_VEC[7:0] and offset 12'hFFF returns RESET_VEC[15:8]. The default RESET_VEC is 16'hD47A.
- R7: After release, any other address with bit 12 set returns (i*37 + 11) mod 256, where i = address bits [ROM_AW-1:0]. ROM_AW defaults to 6, so the ROM is mirrored through the bank.
- R8: Release is sticky. Lowering `boot_ready` afterwards does not bring back the zero hold.
- R9: The hold has no timeout. After thousands of idle cycles without ready, accesses still return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than the bus cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_in | input | 13 | Cartridge address; bit 12 selects the cartridge |
| boot_ready | input | 1 | Asynchronous signal that cartridge initialisation is complete |
| bus_data | output | 8 | Byte placed on the data bus when driving |
| bus_drive | output | 1 | 1 while the block drives the data bus |

## Verification
Each data-path result is due one clock after its address is sampled. The bench changes the address on a falling edge and reads `bus_drive` and `bus_data` on the next falling edge, so exactly one rising edge lies between them. The ready path adds two more edges. The bench therefore raises `boot_ready`, changes the address one cycle later to show the hold is kept, and changes it again only after the synchroniser has filled. Random addresses in both modes are checked against functions that compute the hold, vector and ROM bytes.

// File: rtl/cart_boot_hold.sv
module cart_boot_hold #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int ROM_AW = 6,
  parameter logic [2*DATA_W-1:0] RESET_VEC = 16'hD47A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              boot_ready,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_drive
);
  localparam int OFF_W = ADDR_W - 1;
  localparam logic [OFF_W-1:0] OFF_HI = '1;
  localparam logic [OFF_W-1:0] OFF_LO = {{(OFF_W-1){1'b1}}, 1'b0};

  logic [ADDR_W-1:0] addr_q;
  logic rdy_s1, rdy_s2, serving;
  logic [DATA_W-1:0] byte_sel;

  function automatic logic [DATA_W-1:0] rom_byte(input logic [ROM_AW-1:0] idx);
    logic [DATA_W-1:0] w;
    w = DATA_W'(idx);
    return DATA_W'(w * DATA_W'(37) + DATA_W'(11));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      rdy_s1  <= 1'b0;
      rdy_s2  <= 1'b0;
      serving <= 1'b0;
    end else begin
      addr_q <= addr_in;
      rdy_s1 <= boot_ready;
      rdy_s2 <= rdy_s1;
      if (!serving && rdy_s2 && (addr_in != addr_q))
        serving <= 1'b1;
    end
  end

  always_comb begin
    if (!serving)                        byte_sel = '0;
    else if (addr_q[OFF_W-1:0] == OFF_LO) byte_sel = RESET_VEC[DATA_W-1:0];
    else if (addr_q[OFF_W-1:0] == OFF_HI) byte_sel = RESET_VEC[2*DATA_W-1:DATA_W];
    else                                 byte_sel = rom_byte(addr_q[ROM_AW-1:0]);
  end

  assign bus_drive = addr_q[ADDR_W-1];
  assign bus_data  = bus_drive ? byte_sel : '0;

  p_console_space_undriven_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(addr_in[ADDR_W-1]) |-> (!bus_drive && bus_data == '0));

  p_hold_gives_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !serving |-> bus_data == '0);

  p_release_needs_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(serving) |-> $past(rdy_s2));

  p_release_on_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(serving) |-> $past(addr_in) != $past(addr_in, 2));

  p_release_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    serving |=> serving);
endmodule

// File: tb/cart_boot_hold_bench.sv
`timescale 1ns/1ps
module cart_boot_hold_bench;
  localparam logic [15:0] VEC = 16'hD47A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [12:0] addr_in = '0;
  logic boot_ready = 1'b0;
  logic [7:0] bus_data;
  logic bus_drive;
  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  cart_boot_hold u_cart_boot_hold (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .boot_ready(boot_ready),
    .bus_data(bus_data), .bus_drive(bus_drive)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  function automatic logic [7:0] exp_byte(input logic [12:0] a, input bit serve);
    if (!a[12] || !serve) return 8'h00;
    if (a[11:0] == 12'hFFE) return VEC[7:0];
    if (a[11:0] == 12'hFFF) return VEC[15:8];
    return 8'({2'b00, a[5:0]} * 8'd37 + 8'd11);
  endfunction

  task automatic check(input string req, input logic [12:0] a, input bit serve);
    logic [7:0] ed;
    ed = exp_byte(a, serve);
    n_vec++;
    if (bus_drive !== a[12] || bus_data !== ed) begin
      n_bad++;
      $display("FAIL %s addr=%h: actual drive=%b data=%h expected drive=%b data=%h",
               req, a, bus_drive, bus_data, a[12], ed);
    end
  endtask

  task automatic access(input string req, input logic [12:0] a, input bit serve);
    addr_in = a;
    @(negedge clk);
    check(req, a, serve);
  endtask

  initial begin
    logic [12:0] a;
    a = 13'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    n_vec++;
    if (bus_drive !== 1'b0 || bus_data !== 8'h00) begin
      n_bad++;
      $display("FAIL R1 in reset: actual drive=%b data=%h expected 0/00", bus_drive, bus_data);
    end
    addr_in = 13'h1234;
    rst_n = 1'b1;
    n_vec++;
    if (bus_drive !== 1'b0 || bus_data !== 8'h00) begin
      n_bad++;
      $display("FAIL R1 after reset: actual drive=%b data=%h expected 0/00", bus_drive, bus_data);
    end
    @(negedge clk);
    check("R2", 13'h1234, 0);

    access("R2 vec lo held", 13'h1FFE, 0);
    access("R2 vec hi held", 13'h1FFF, 0);
    access("R3 hold console", 13'h0FFE, 0);
    for (int i = 0; i < 300; i++) begin
      a = 13'($urandom);
      access(a[12] ? "R2 random hold" : "R3 random hold", a, 0);
    end

    addr_in = 13'h1ABC;
    repeat (3000) @(negedge clk);
    check("R9 long hold", 13'h1ABC, 0);

    access("R2", 13'h1FFE, 0);
    boot_ready = 1'b1;
    @(negedge clk);
    access("R4 sync delay", 13'h1FFD, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R5 no change", 13'h1FFD, 0);
    end
    access("R6 vec hi", 13'h1FFF, 1);
    access("R6 vec lo", 13'h1FFE, 1);
    access("R3 serve console", 13'h0FFF, 1);
    access("R7 rom idx0", 13'h1000, 1);
    access("R7 rom mirror", 13'h17FF, 1);

    for (int i = 0; i < 300; i++) begin
      a = 13'($urandom);
      if (i % 50 == 0) a = {1'b1, 11'h7FF, 1'b0} | 13'h0800;
      access(a[12] ? "R7 random serve" : "R3 random serve", a, 1);
    end

    boot_ready = 1'b0;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 100; i++) begin
      a = 13'($urandom);
      access("R8 sticky", a, 1);
    end
    access("R8 vec lo", 13'h1FFE, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule